// File: doc/BRIEF.md
# Reaction Time Measurement Controller

This block runs a reaction test on a board with two pushbuttons, a stimulus light and a four-digit decimal display. A start press clears the display to zero and arms a trial. After a pseudo-random wait the stimulus output turns on, and the block counts whole milliseconds until the stop press. The count goes to the display as four BCD digits. A stop press that comes too early, or no press within a second, ends the trial with the saturated value 999.

Eight trials make one set. Each trial is started by its own start press, and each result is kept in its own register. After the eighth trial the display shows the integer average of the set, and a done flag stays high until the next start press begins a new set. The buttons are expected to be debounced already and to give one-cycle pulses. Display multiplexing is handled elsewhere.

Top module: `rxn_timer`

## Requirements
- R1: While reset is applied, and after it is released, stim_on, avg_done and false_start are 0 and bcd_digits is 0x0000.
- R2: When no trial is running, a start pulse begins a trial, and bcd_digits reads 0x0000 in the cycle after the accepting edge.
- R3: The stimulus rises a whole number of millisecond ticks after the accepting edge. The number is DELAY_MIN_MS plus (LFSR value mod DELAY_SPAN_MS), so it always lies between DELAY_MIN_MS and DELAY_MIN_MS+DELAY_SPAN_MS-1. The LFSR is a free-running 16-bit register with a nonzero seed, and its value is sampled at the start edge.
- R4: While the stimulus is on, a stop pulse ends the trial and stim_on falls in the next cycle. The result is the number of complete millisecond ticks (TICK_DIV clocks each) since stim_on rose.
- R5: If no stop pulse arrives, stim_on stays high for exactly 1000 ticks, and then the trial ends with result 999.
- R6: A stop pulse during the wait is a false start. The trial ends with result 999, the stimulus does not come on, and false_start goes to 1. The next start pulse clears false_start.
- R7: Each result from trials one to seven is shown as BCD within 16 clocks of the trial's end. Bits [15:12] hold thousands, [11:8] hundreds, [7:4] tens and [3:0] units, and every digit is at most 9.
- R8: After the eighth trial, avg_done goes to 1 and stim_on stays 0. Within 16 clocks, bcd_digits shows floor(sum of the eight results / 8).
- R9: A start pulse while avg_done is 1 clears avg_done and begins a fresh set of eight trials. The next average uses only the new results.
- R10: Asserting reset during a trial or during the average display returns the block to idle at once, with the outputs as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| start_pls | input | 1 | One-cycle debounced start press |
| stop_pls | input | 1 | One-cycle debounced stop press |
| stim_on | output | 1 | Stimulus light drive |
| bcd_digits | output | 16 | Four BCD digits of the displayed value |
| avg_done | output | 1 | High while the average of a completed set is shown |
| false_start | output | 1 | Stop was pressed before the stimulus in the current trial |

## Verification
The display is cleared on the clock after the start is accepted. A stop press ends the trial on the edge where it is sampled, and stim_on falls one clock later. A trial result reaches the digits 11 clocks after the trial ends, and the average reaches them 12 clocks after the eighth trial ends. The bench times each press from the negative edge on which stim_on is first seen high. It places stop in the middle of a tick so that the expected count is exact, and it checks the timeout on the exact cycle before and after it. Expected digits go into a queue, and a monitor compares each one 16 clocks after it was queued, which lies after both deadlines and before the next start press.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
  localparam int DIGITS = 4;
  localparam int LFSR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STIM,
    ST_SHOW,
    ST_AVG,
    ST_DONE
  } rxn_state_e;
endpackage

// File: rtl/rxn_rst_sync.sv
module rxn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/rxn_lfsr.sv
module rxn_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] value
);
  logic [15:0] q_q, q_d;

  always_comb q_d = {q_q[14:0], q_q[15] ^ q_q[13] ^ q_q[12] ^ q_q[10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= SEED;
    else        q_q <= q_d;
  end

  assign value = q_q;
endmodule

// File: rtl/rxn_tick.sv
module rxn_tick #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr || cnt_q == LAST) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/rxn_bcd.sv
module rxn_bcd #(
  parameter int BIN_W  = 10,
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [BIN_W-1:0]      bin,
  output logic                  done,
  output logic [4*DIGITS-1:0]   bcd
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(BIN_W + 1);

  logic [BIN_W-1:0] sh_q;
  logic [BCD_W-1:0] acc_q, adj;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_adj
    assign adj[4*g +: 4] = (acc_q[4*g +: 4] >= 4'd5) ? acc_q[4*g +: 4] + 4'd3
                                                      : acc_q[4*g +: 4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (go) begin
      sh_q   <= bin;
      acc_q  <= '0;
      cnt_q  <= CNT_W'(BIN_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      acc_q  <= {adj[BCD_W-2:0], sh_q[BIN_W-1]};
      sh_q   <= sh_q << 1;
      cnt_q  <= cnt_q - 1'b1;
      busy_q <= (cnt_q != CNT_W'(1));
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done = done_q;
  assign bcd  = acc_q;
endmodule

// File: rtl/rxn_timer.sv
module rxn_timer
  import rxn_pkg::*;
#(
  parameter int          TICK_DIV      = 100000,
  parameter int          DELAY_MIN_MS  = 1000,
  parameter int          DELAY_SPAN_MS = 9000,
  parameter int          MAX_MS        = 999,
  parameter int          TRIALS_LOG2   = 3,
  parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_pls,
  input  logic        stop_pls,
  output logic        stim_on,
  output logic [15:0] bcd_digits,
  output logic        avg_done,
  output logic        false_start
);
  localparam int N_TRIALS = 1 << TRIALS_LOG2;
  localparam int RES_W    = $clog2(MAX_MS + 1);
  localparam int SUM_W    = RES_W + TRIALS_LOG2;
  localparam int MS_TOP   = (DELAY_MIN_MS + DELAY_SPAN_MS > MAX_MS + 1)
                            ? DELAY_MIN_MS + DELAY_SPAN_MS : MAX_MS + 1;
  localparam int MS_W     = $clog2(MS_TOP + 1);

  logic             rst_s_n;
  rxn_state_e       state_q, state_d;
  logic [MS_W-1:0]  ms_q, ms_d, dly_q, dly_d;
  logic [TRIALS_LOG2-1:0] idx_q, idx_d;
  logic             err_q, err_d;
  logic [RES_W-1:0] res_q [N_TRIALS];
  logic [SUM_W-1:0] sum;
  logic             tick, tick_clr, clr_disp;
  logic             end_trial, conv_go, conv_done;
  logic [RES_W-1:0] end_val, conv_bin;
  logic [15:0]      lfsr, conv_bcd, bcd_q;

  rxn_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));
  rxn_lfsr #(.SEED(LFSR_SEED)) i_lfsr (.clk(clk), .rst_n(rst_s_n), .value(lfsr));
  rxn_tick #(.DIV(TICK_DIV)) i_tick (.clk(clk), .rst_n(rst_s_n), .clr(tick_clr), .tick(tick));
  rxn_bcd #(.BIN_W(RES_W), .DIGITS(DIGITS)) i_bcd (
    .clk(clk), .rst_n(rst_s_n), .go(conv_go), .bin(conv_bin),
    .done(conv_done), .bcd(conv_bcd));

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_TRIALS; i++) sum = sum + SUM_W'(res_q[i]);
  end

  always_comb begin
    state_d   = state_q;
    ms_d      = ms_q;
    dly_d     = dly_q;
    idx_d     = idx_q;
    err_d     = err_q;
    tick_clr  = 1'b0;
    clr_disp  = 1'b0;
    end_trial = 1'b0;
    end_val   = '0;
    conv_go   = 1'b0;
    conv_bin  = '0;
    case (state_q)
      ST_IDLE, ST_SHOW, ST_DONE: begin
        if (start_pls) begin
          state_d  = ST_WAIT;
          ms_d     = '0;
          dly_d    = MS_W'(DELAY_MIN_MS) + MS_W'(32'(lfsr) % 32'(DELAY_SPAN_MS));
          err_d    = 1'b0;
          tick_clr = 1'b1;
          clr_disp = 1'b1;
        end
      end
      ST_WAIT: begin
        if (stop_pls) begin
          end_trial = 1'b1;
          end_val   = RES_W'(MAX_MS);
          err_d     = 1'b1;
        end else if (tick) begin
          if (ms_q == dly_q - 1'b1) begin
            state_d  = ST_STIM;
            ms_d     = '0;
            tick_clr = 1'b1;
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end
      end
      ST_STIM: begin
        if (stop_pls) begin
          end_trial = 1'b1;
          end_val   = ms_q[RES_W-1:0];
        end else if (tick) begin
          if (ms_q == MS_W'(MAX_MS)) begin
            end_trial = 1'b1;
            end_val   = RES_W'(MAX_MS);
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end
      end
      ST_AVG: begin
        state_d  = ST_DONE;
        conv_go  = 1'b1;
        conv_bin = RES_W'(sum >> TRIALS_LOG2);
      end
      default: state_d = ST_IDLE;
    endcase
    if (end_trial) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == TRIALS_LOG2'(N_TRIALS - 1)) begin
        state_d = ST_AVG;
      end else begin
        state_d  = ST_SHOW;
        conv_go  = 1'b1;
        conv_bin = end_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      ms_q    <= '0;
      dly_q   <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ms_q    <= ms_d;
      dly_q   <= dly_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int i = 0; i < N_TRIALS; i++) res_q[i] <= '0;
    end else if (end_trial) begin
      for (int i = 0; i < N_TRIALS; i++)
        if (idx_q == TRIALS_LOG2'(i)) res_q[i] <= end_val;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)
      bcd_q <= '0;
    else if (clr_disp)
      bcd_q <= '0;
    else if (conv_done && (state_q == ST_SHOW || state_q == ST_DONE))
      bcd_q <= conv_bcd;
  end

  assign stim_on     = (state_q == ST_STIM);
  assign avg_done    = (state_q == ST_DONE);
  assign false_start = err_q;
  assign bcd_digits  = bcd_q;
endmodule

// File: rtl/rxn_timer_chk.sv
module rxn_timer_chk
  import rxn_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start_pls,
  input logic        stop_pls,
  input logic        stim_on,
  input logic [15:0] bcd_digits,
  input logic        avg_done,
  input logic        false_start,
  input rxn_state_e  state_q
);
  logic idle_like;
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_SHOW) || (state_q == ST_DONE);

  p_digit_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_digits[3:0] <= 4'd9) && (bcd_digits[7:4] <= 4'd9) &&
    (bcd_digits[11:8] <= 4'd9) && (bcd_digits[15:12] <= 4'd9));

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pls && idle_like) |=> (bcd_digits == 16'h0000) && !avg_done);

  p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && stop_pls) |=> (false_start && !stim_on));

  p_stop_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_on && stop_pls) |=> !stim_on);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    avg_done |-> !stim_on);

  p_stim_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stim_on) |-> ($past(state_q) == ST_WAIT));
endmodule

bind rxn_timer rxn_timer_chk i_chk (
  .clk(clk), .rst_n(rst_s_n), .start_pls(start_pls), .stop_pls(stop_pls),
  .stim_on(stim_on), .bcd_digits(bcd_digits), .avg_done(avg_done),
  .false_start(false_start), .state_q(state_q));

// File: tb/test_rxn_timer.sv
`timescale 1ns/1ps
module test_rxn_timer;
  localparam int TDIV  = 4;
  localparam int DMIN  = 10;
  localparam int DSPAN = 20;

  logic        clk = 1'b0;
  logic        rst_n, start_pls, stop_pls;
  logic        stim_on, avg_done, false_start;
  logic [15:0] bcd_digits;

  typedef struct { logic [15:0] val; string req; } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  int total;

  rxn_timer #(.TICK_DIV(TDIV), .DELAY_MIN_MS(DMIN), .DELAY_SPAN_MS(DSPAN)) i_rxn_timer (
    .clk(clk), .rst_n(rst_n), .start_pls(start_pls), .stop_pls(stop_pls),
    .stim_on(stim_on), .bcd_digits(bcd_digits), .avg_done(avg_done),
    .false_start(false_start));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] to_bcd(int v);
    return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic press_start();
    @(negedge clk); start_pls = 1'b1;
    @(negedge clk); start_pls = 1'b0;
  endtask

  task automatic press_stop();
    stop_pls = 1'b1;
    @(negedge clk); stop_pls = 1'b0;
  endtask

  // kind: 0 normal stop after d ms, 1 false start, 2 timeout
  task automatic run_trial(int kind, int d, bit last, output int res);
    int c;
    press_start();
    check(bcd_digits == 16'h0, "R2 digits cleared", bcd_digits, 0);
    check(avg_done == 1'b0, "R9 done cleared by start", avg_done, 0);
    check(false_start == 1'b0, "R6 error cleared by start", false_start, 0);
    if (kind == 1) begin
      repeat (2) @(negedge clk);
      press_stop();
      check(false_start == 1'b1, "R6 false start flag", false_start, 1);
      check(stim_on == 1'b0, "R6 no stimulus", stim_on, 0);
      res = 999;
    end else begin
      c = 1;
      while (!stim_on && c < 100000) begin @(negedge clk); c++; end
      check(((c - 1) % TDIV == 0) && ((c - 1) / TDIV >= DMIN) && ((c - 1) / TDIV < DMIN + DSPAN),
            "R3 delay window", (c - 1) / TDIV, DMIN);
      if (kind == 0) begin
        repeat (d * TDIV + TDIV / 2) @(negedge clk);
        check(stim_on == 1'b1, "R4 stimulus held until stop", stim_on, 1);
        press_stop();
        check(stim_on == 1'b0, "R4 stimulus drops after stop", stim_on, 0);
        res = d;
      end else begin
        repeat (1000 * TDIV - 1) @(negedge clk);
        check(stim_on == 1'b1, "R5 still on before timeout", stim_on, 1);
        @(negedge clk);
        check(stim_on == 1'b0, "R5 off at timeout", stim_on, 0);
        res = 999;
      end
    end
    total += res;
    if (!last) exp_q.push_back('{to_bcd(res), "R7 trial digits"});
    else       exp_q.push_back('{to_bcd(total / 8), "R8 average digits"});
    repeat (20) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (exp_q.size() > 0);
      repeat (16) @(negedge clk);
      e = exp_q.pop_front();
      check(bcd_digits == e.val, e.req, bcd_digits, e.val);
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int r;
    int kinds_a [8] = '{0, 0, 1, 2, 0, 0, 0, 0};
    int ds_a    [8] = '{5, 0, 0, 0, 250, 37, 999, 1};
    rst_n = 1'b0; start_pls = 1'b0; stop_pls = 1'b0;
    repeat (3) @(negedge clk);
    check(stim_on == 0 && avg_done == 0 && false_start == 0 && bcd_digits == 0,
          "R1 outputs during reset", {stim_on, avg_done, false_start}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(stim_on == 0 && avg_done == 0 && false_start == 0 && bcd_digits == 0,
          "R1 outputs after reset", bcd_digits, 0);

    total = 0;
    for (int i = 0; i < 8; i++) run_trial(kinds_a[i], ds_a[i], i == 7, r);
    check(avg_done == 1'b1, "R8 done after eighth trial", avg_done, 1);
    check(stim_on == 1'b0, "R8 stimulus off while done", stim_on, 0);

    total = 0;
    for (int i = 0; i < 8; i++) run_trial(0, 3 * i + 1, i == 7, r);
    check(avg_done == 1'b1, "R9 second set done", avg_done, 1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(avg_done == 0 && bcd_digits == 0, "R10 reset during done", bcd_digits, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    press_start();
    while (!stim_on) @(negedge clk);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(stim_on == 0 && false_start == 0 && bcd_digits == 0, "R10 reset during stimulus", stim_on, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(stim_on == 0 && avg_done == 0, "R10 idle after reset", stim_on, 0);

    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule